// File: doc/BRIEF.md
# Chained Block-Cipher Message Tag Generator

This block produces a 128-bit authentication tag for one bus message. The message is a 128-bit payload, an 11-bit message identifier and an 11-bit freshness counter, and the tag is formed under a 128-bit secret key. One iterative AES-128 encryption core is run four times in a fixed chain:

1. Derive a subkey by encrypting the all-zero block.
2. Encrypt the payload.
3. Encrypt that result XORed with a block that holds the identifier and freshness value.
4. Encrypt the second result XORed with the subkey. This output is the tag.

A stage begins only when the previous encryption has finished and the enable input is high. A host raises `en`, keeps the message inputs and key steady until `done` pulses, and then reads `mac`. The tag stays on `mac` until the next run completes.

Top module: `mac_gen`

## Requirements
- R1: While reset is active and after it is released, `done` is 0 and `mac` is all zeros until the first run completes.
- R2: The subkey is AES-128 of the all-zero 128-bit block under `key`. The byte `key[127:120]` is the first key byte, and blocks use the same byte order.
- R3: The first chained encryption takes `data` as its plaintext under `key`, giving C1.
- R4: The second encryption takes C1 XOR F. F is a 128-bit block with `id` in bits [21:11], `fv` in bits [10:0] and zeros in bits [127:22]. Its result is C2.
- R5: The tag placed on `mac` is AES-128 of (C2 XOR subkey) under `key`.
- R6: When `en` is sampled high at a clock edge while the block is idle, and stays high, `done` is high for exactly one cycle. That cycle follows the 44th clock edge after the accepting edge.
- R7: If `en` is low when a non-final stage completes, the next stage waits until `en` is high again. `done` stays 0 while it waits, and the tag produced afterwards is unchanged by the pause.
- R8: While the block is idle and `en` is low, no run starts: `done` stays 0 and `mac` keeps its value.
- R9: `mac` changes only in a cycle in which `done` is high, and holds its value between runs.
- R10: If `en` stays high through the `done` cycle, the next run is accepted at the edge that ends the `done` cycle. Its own `done` follows 44 edges later, and its tag is computed from the inputs present at that acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Start a run when idle; gates each following stage |
| key | input | 128 | Secret key, held steady during a run |
| data | input | 128 | Message payload, held steady during a run |
| id | input | 11 | Message identifier |
| fv | input | 11 | Freshness value |
| mac | output | 128 | Authentication tag, registered |
| done | output | 1 | One-cycle strobe when `mac` has just been updated |

## Verification
Two functions can fall in the same cycle. When `en` is held high across a run, the completion strobe of one tag coincides with the acceptance of the next run. The bench provokes this by keeping `en` high at the `done` cycle and changing every input in that cycle. It then judges that the old tag stays on `mac` until the second `done`, and that the second tag and its latency match a software model fed only the new inputs. A pause of `en` in the middle of a run is also applied, to show that stage gating delays `done` without changing the tag.

// File: rtl/macgen_pkg.sv
package macgen_pkg;
  localparam int BLK_W = 128;
  localparam int NR    = 10;
  localparam int NSTG  = 4;

  typedef enum logic {PH_IDLE, PH_BUSY} phase_t;

  function automatic logic [7:0] xt(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, aa;
    acc = 8'h00;
    aa  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ aa;
      aa = xt(aa);
    end
    return acc;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] b, input int n);
    return (b << n) | (b >> (8 - n));
  endfunction

  // inverse as x^254, then the affine map
  function automatic logic [7:0] sbox(input logic [7:0] x);
    logic [7:0] p, r;
    p = gmul(x, x);
    r = p;
    for (int i = 0; i < 6; i++) begin
      p = gmul(p, p);
      r = gmul(r, p);
    end
    return r ^ rotl8(r, 1) ^ rotl8(r, 2) ^ rotl8(r, 3) ^ rotl8(r, 4) ^ 8'h63;
  endfunction

  function automatic logic [BLK_W-1:0] next_key(input logic [BLK_W-1:0] k, input logic [7:0] rc);
    logic [31:0] w3, t, n0, n1, n2, n3;
    w3 = k[31:0];
    t  = {sbox(w3[23:16]) ^ rc, sbox(w3[15:8]), sbox(w3[7:0]), sbox(w3[31:24])};
    n0 = k[127:96] ^ t;
    n1 = k[95:64] ^ n0;
    n2 = k[63:32] ^ n1;
    n3 = k[31:0] ^ n2;
    return {n0, n1, n2, n3};
  endfunction

  function automatic logic [BLK_W-1:0] aes_round(input logic [BLK_W-1:0] st,
                                                 input logic [BLK_W-1:0] rk,
                                                 input logic last);
    logic [7:0] b [16];
    logic [7:0] n [16];
    logic [7:0] a0, a1, a2, a3;
    logic [BLK_W-1:0] o;
    for (int j = 0; j < 16; j++) b[j] = sbox(st[127-8*j -: 8]);
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) n[4*c+r] = b[4*((c+r)%4)+r];
    if (!last) begin
      for (int c = 0; c < 4; c++) begin
        a0 = n[4*c]; a1 = n[4*c+1]; a2 = n[4*c+2]; a3 = n[4*c+3];
        n[4*c]   = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
        n[4*c+1] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
        n[4*c+2] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
        n[4*c+3] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
      end
    end
    for (int j = 0; j < 16; j++) o[127-8*j -: 8] = n[j];
    return o ^ rk;
  endfunction
endpackage

// File: rtl/mac_aes_core.sv
module mac_aes_core
  import macgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [BLK_W-1:0] key,
  input  logic [BLK_W-1:0] blk,
  output logic [BLK_W-1:0] ct,
  output logic             valid
);
  localparam int RW = $clog2(NR + 1);

  logic [BLK_W-1:0] st, rk;
  logic [7:0]       rc;
  logic [RW-1:0]    rnd;
  logic             busy;

  wire [BLK_W-1:0] nk   = next_key(rk, rc);
  wire             last = (rnd == RW'(NR));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= '0; rk <= '0; rc <= 8'h01; rnd <= '0; busy <= 1'b0; valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (start && !busy) begin
        st   <= blk ^ key;
        rk   <= key;
        rc   <= 8'h01;
        rnd  <= RW'(1);
        busy <= 1'b1;
      end else if (busy) begin
        rk  <= nk;
        rc  <= xt(rc);
        st  <= aes_round(st, nk, last);
        rnd <= rnd + RW'(1);
        if (last) begin
          busy  <= 1'b0;
          valid <= 1'b1;
        end
      end
    end
  end

  assign ct = st;

  // R6: the sequencer never requests an encryption while one is in flight
  assert_start_idle_R6: assert property (@(posedge clk) disable iff (!rst_n) start |-> !busy);
  // R6: completion is a single-cycle event
  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n) valid |=> !valid);
endmodule

// File: rtl/mac_seq.sv
module mac_seq
  import macgen_pkg::*;
#(
  parameter int ID_W = 11,
  parameter int FV_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [BLK_W-1:0] data,
  input  logic [ID_W-1:0]  id,
  input  logic [FV_W-1:0]  fv,
  input  logic [BLK_W-1:0] core_ct,
  input  logic             core_valid,
  output logic             core_start,
  output logic [BLK_W-1:0] core_blk,
  output logic [BLK_W-1:0] mac,
  output logic             done
);
  localparam int PAD_W = BLK_W - ID_W - FV_W;
  localparam int STG_W = $clog2(NSTG);
  localparam logic [STG_W-1:0] LAST_STG = STG_W'(NSTG - 1);

  phase_t           phase;
  logic [STG_W-1:0] stage;
  logic             pend;
  logic [BLK_W-1:0] subkey;

  wire [BLK_W-1:0] frame      = {{PAD_W{1'b0}}, id, fv};
  wire             step_ready = (phase == PH_BUSY) && (core_valid || pend) && (stage != LAST_STG);
  wire             final_hit  = (phase == PH_BUSY) && core_valid && (stage == LAST_STG);
  wire [STG_W-1:0] nstage     = (phase == PH_IDLE) ? '0 : stage + STG_W'(1);

  assign core_start = en && ((phase == PH_IDLE) || step_ready);

  always_comb begin
    case (nstage)
      STG_W'(0): core_blk = '0;
      STG_W'(1): core_blk = data;
      STG_W'(2): core_blk = core_ct ^ frame;
      default:   core_blk = core_ct ^ subkey;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE; stage <= '0; pend <= 1'b0;
      subkey <= '0; mac <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (core_start) begin
        phase <= PH_BUSY;
        stage <= nstage;
        pend  <= 1'b0;
      end else if (core_valid && !final_hit) begin
        pend <= 1'b1;
      end
      if (core_valid && stage == '0) subkey <= core_ct;
      if (final_hit) begin
        phase <= PH_IDLE;
        mac   <= core_ct;
        done  <= 1'b1;
      end
    end
  end

  assert_pause_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !en) |=> (pend && $stable(stage)));
  assert_mac_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(mac));
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_valid_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    core_valid |-> (phase == PH_BUSY));
endmodule

// File: rtl/mac_gen.sv
module mac_gen
  import macgen_pkg::*;
#(
  parameter int ID_W = 11,
  parameter int FV_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [BLK_W-1:0] key,
  input  logic [BLK_W-1:0] data,
  input  logic [ID_W-1:0]  id,
  input  logic [FV_W-1:0]  fv,
  output logic [BLK_W-1:0] mac,
  output logic             done
);
  logic             core_start, core_valid;
  logic [BLK_W-1:0] core_blk, core_ct;

  mac_aes_core u_core (
    .clk(clk), .rst_n(rst_n), .start(core_start), .key(key),
    .blk(core_blk), .ct(core_ct), .valid(core_valid)
  );

  mac_seq #(.ID_W(ID_W), .FV_W(FV_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .data(data), .id(id), .fv(fv),
    .core_ct(core_ct), .core_valid(core_valid), .core_start(core_start),
    .core_blk(core_blk), .mac(mac), .done(done)
  );
endmodule

// File: tb/sim_mac_gen.sv
module sim_mac_gen;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0;
  logic [127:0] key = '0, data = '0;
  logic [10:0]  id = '0, fv = '0;
  logic [127:0] mac;
  logic         done;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  mac_gen u0 (.clk(clk), .rst_n(rst_n), .en(en), .key(key), .data(data),
              .id(id), .fv(fv), .mac(mac), .done(done));

  // ---------- software model ----------
  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 0, x = a, y = b;
    while (y != 0) begin
      if (y[0]) p ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
      y = y >> 1;
    end
    return p;
  endfunction

  function automatic logic [7:0] m_sbox(input logic [7:0] x);
    logic [7:0] inv = 0, o;
    if (x != 0)
      for (int i = 1; i < 256; i++) if (m_mul(x, 8'(i)) == 8'h01) inv = 8'(i);
    for (int i = 0; i < 8; i++)
      o[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 1);
    return o;
  endfunction

  function automatic logic [127:0] m_aes(input logic [127:0] k, input logic [127:0] p);
    logic [7:0] w [176];
    logic [7:0] s [16];
    logic [7:0] n [16];
    logic [7:0] t [4];
    logic [7:0] rc = 8'h01;
    logic [127:0] o;
    for (int i = 0; i < 16; i++) w[i] = k[127-8*i -: 8];
    for (int i = 16; i < 176; i += 4) begin
      for (int j = 0; j < 4; j++) t[j] = w[i-4+j];
      if (i % 16 == 0) begin
        logic [7:0] t0;
        t0 = t[0];
        t[0] = m_sbox(t[1]) ^ rc; t[1] = m_sbox(t[2]); t[2] = m_sbox(t[3]); t[3] = m_sbox(t0);
        rc = m_mul(rc, 8'h02);
      end
      for (int j = 0; j < 4; j++) w[i+j] = w[i-16+j] ^ t[j];
    end
    for (int j = 0; j < 16; j++) s[j] = p[127-8*j -: 8] ^ w[j];
    for (int r = 1; r <= 10; r++) begin
      for (int j = 0; j < 16; j++) s[j] = m_sbox(s[j]);
      for (int c = 0; c < 4; c++)
        for (int q = 0; q < 4; q++) n[4*c+q] = s[4*((c+q)%4)+q];
      for (int c = 0; c < 4; c++) begin
        if (r < 10) begin
          s[4*c]   = m_mul(n[4*c],8'd2) ^ m_mul(n[4*c+1],8'd3) ^ n[4*c+2] ^ n[4*c+3];
          s[4*c+1] = n[4*c] ^ m_mul(n[4*c+1],8'd2) ^ m_mul(n[4*c+2],8'd3) ^ n[4*c+3];
          s[4*c+2] = n[4*c] ^ n[4*c+1] ^ m_mul(n[4*c+2],8'd2) ^ m_mul(n[4*c+3],8'd3);
          s[4*c+3] = m_mul(n[4*c],8'd3) ^ n[4*c+1] ^ n[4*c+2] ^ m_mul(n[4*c+3],8'd2);
        end else
          for (int q = 0; q < 4; q++) s[4*c+q] = n[4*c+q];
      end
      for (int j = 0; j < 16; j++) s[j] ^= w[16*r+j];
    end
    for (int j = 0; j < 16; j++) o[127-8*j -: 8] = s[j];
    return o;
  endfunction

  function automatic logic [127:0] m_tag(input logic [127:0] k, input logic [127:0] d,
                                         input logic [10:0] i, input logic [10:0] f);
    logic [127:0] sk, c1, c2, fr;
    fr = 128'(i) << 11 | 128'(f);
    sk = m_aes(k, 128'h0);
    c1 = m_aes(k, d);
    c2 = m_aes(k, c1 ^ fr);
    return m_aes(k, c2 ^ sk);
  endfunction

  // ---------- checking ----------
  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_mac(input logic [127:0] k, input logic [127:0] d,
                         input logic [10:0] i, input logic [10:0] f,
                         input bit keep_en, output logic [127:0] m, output int lat);
    key = k; data = d; id = i; fv = f; en = 1'b1;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!done && lat < 300);
    m = mac;
    if (!keep_en) en = 1'b0;
  endtask

  localparam logic [277:0] VEC [0:5] = '{
    {128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff, 11'h123, 11'h456},
    {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h6bc1bee22e409f96e93d7e117393172a, 11'h000, 11'h000},
    {128'h0, 128'h0, 11'h000, 11'h000},
    {128'hffffffffffffffffffffffffffffffff, 128'hffffffffffffffffffffffffffffffff, 11'h7ff, 11'h7ff},
    {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h6bc1bee22e409f96e93d7e117393172a, 11'h7ff, 11'h000},
    {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h6bc1bee22e409f96e93d7e117393172a, 11'h000, 11'h7ff}
  };

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [127:0] m, prev;
    int lat;
    bit quiet;
    // model sanity against published single-block vectors (R2 subkey path)
    check("R2 model FIPS", m_aes(128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff),
          128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    check("R2 model zero-block", m_aes(128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0),
          128'h7df76b0c1ab899b33e42f047b91b546f);

    repeat (3) @(negedge clk);
    check("R1 reset done", 128'(done), 128'h0);
    check("R1 reset mac", mac, 128'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset mac", mac, 128'h0);

    // R8: idle with en low
    quiet = 1;
    for (int c = 0; c < 60; c++) begin @(negedge clk); if (done) quiet = 0; end
    check("R8 no run while en low", 128'(quiet), 128'h1);
    check("R8 mac unchanged", mac, 128'h0);

    // table walk: R3 R4 R5 R6
    for (int v = 0; v < 6; v++) begin
      run_mac(VEC[v][277:150], VEC[v][149:22], VEC[v][21:11], VEC[v][10:0], 0, m, lat);
      check($sformatf("R5 tag vector %0d", v), m,
            m_tag(VEC[v][277:150], VEC[v][149:22], VEC[v][21:11], VEC[v][10:0]));
      check($sformatf("R6 latency vector %0d", v), 128'(lat), 128'd45);
      @(negedge clk);
      check($sformatf("R6 done one cycle vector %0d", v), 128'(done), 128'h0);
    end

    // R4: id and fv swapped give distinct, model-predicted tags
    run_mac(VEC[4][277:150], VEC[4][149:22], 11'h001, 11'h002, 0, m, lat);
    check("R4 field order", m, m_tag(VEC[4][277:150], VEC[4][149:22], 11'h001, 11'h002));
    prev = m;
    run_mac(VEC[4][277:150], VEC[4][149:22], 11'h002, 11'h001, 0, m, lat);
    check("R4 swapped fields", m, m_tag(VEC[4][277:150], VEC[4][149:22], 11'h002, 11'h001));
    check("R3 payload differs from tag", 128'(m != prev), 128'h1);

    // R9: hold between runs
    prev = mac;
    repeat (25) @(negedge clk);
    check("R9 mac held idle", mac, prev);

    // R7: pause mid-run
    key = VEC[0][277:150]; data = VEC[0][149:22]; id = 11'h3a5; fv = 11'h05c; en = 1'b1;
    repeat (5) @(negedge clk);
    en = 1'b0;
    quiet = 1;
    for (int c = 0; c < 30; c++) begin @(negedge clk); if (done) quiet = 0; end
    check("R7 no done during pause", 128'(quiet), 128'h1);
    check("R9 mac held during pause", mac, prev);
    en = 1'b1;
    lat = 35;
    do begin @(negedge clk); lat++; end while (!done && lat < 300);
    en = 1'b0;
    check("R7 tag after pause", mac, m_tag(VEC[0][277:150], VEC[0][149:22], 11'h3a5, 11'h05c));
    check("R7 pause delays done", 128'(lat > 45), 128'h1);
    @(negedge clk);

    // R10: back-to-back with en held, inputs changed in the done cycle
    run_mac(VEC[1][277:150], VEC[1][149:22], 11'h0aa, 11'h155, 1, m, lat);
    check("R10 first tag", m, m_tag(VEC[1][277:150], VEC[1][149:22], 11'h0aa, 11'h155));
    prev = m;
    key = VEC[3][277:150]; data = VEC[0][149:22]; id = 11'h7f0; fv = 11'h00f;
    lat = 0;
    quiet = 1;
    do begin
      @(negedge clk); lat++;
      if (!done && mac !== prev) quiet = 0;
    end while (!done && lat < 300);
    en = 1'b0;
    check("R9 old tag held until second done", 128'(quiet), 128'h1);
    check("R10 second latency", 128'(lat), 128'd45);
    check("R10 second tag", mac, m_tag(VEC[3][277:150], VEC[0][149:22], 11'h7f0, 11'h00f));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule